// File: doc/BRIEF.md
# Programmable FIFO Flag Offset Loader

This block keeps the two threshold offsets that a FIFO's almost-empty and almost-full comparators use. One offset sits in the empty-side register and one in the full-side register. Each is `OFS_W` bits wide, and both feed the comparators continuously on `empty_ofs` and `full_ofs`. The FIFO storage and the comparators are outside this block.

A configuration select `cfg_sel` splits the strobe space. With `cfg_sel` low, the write, read and serial strobes act on the offsets. A lone write strobe writes the offsets in parallel from `wdata`. A lone read strobe reads one offset back. A lone serial strobe shifts one bit in from `ser_in`. With `cfg_sel` high, the write and read strobes become the `mem_wr` and `mem_rd` qualifiers of the FIFO array. Master reset loads default offsets chosen by the level of `cfg_sel`. It also latches `prog_serial`, which fixes the loading method until the next master reset.

Data enters on `wdata` and is qualified by `wr_req`. Data leaves on `rb_data` and is qualified by `rb_valid`. The readback stream has no ready signal. Back-pressure is applied only by holding back `rd_req`, because each read strobe is itself the request for exactly one beat. That beat is valid for one cycle and is never repeated.

Top module: `ofs_loader`

## Requirements
- R1: A clock edge with `mrst` high and `cfg_sel` low sets both offsets to 0x007F after that edge. It also returns both access pointers to the empty-side register, clears `rb_valid` and clears `rb_data` to zero.
- R2: A clock edge with `mrst` high and `cfg_sel` high sets both offsets to 0x03FF after that edge.
- R3: The loading method is serial when `prog_serial` is 1 and parallel when it is 0. It is sampled only on edges with `mrst` high. Changes of `prog_serial` at other times have no effect.
- R4: In parallel mode, each edge with `cfg_sel` low, `wr_req` high, `rd_req` low and `ser_en` low writes `wdata` into one register. The first write after reset goes to the empty-side register and the next to the full-side register, alternating from then on.
- R5: In serial mode, parallel write strobes leave both offsets unchanged. In parallel mode, serial strobes leave both offsets unchanged.
- R6: In serial mode, each edge with `cfg_sel` low and `ser_en` as the only strobe shifts `ser_in` into a 2*`OFS_W`-bit chain. The first bit shifted lands, after 2*`OFS_W` shifts, in bit 0 of the empty-side register, and the last lands in the top bit of the full-side register.
- R7: In either mode, an edge with `cfg_sel` low and `rd_req` as the only strobe raises `rb_valid` for the next cycle. The value on `rb_data` alternates between the empty-side offset (first after reset) and the full-side offset.
- R8: `mem_wr` equals `cfg_sel & wr_req` and `mem_rd` equals `cfg_sel & rd_req`, combinationally. Both are forced low while `mrst` is high, and neither is ever high while `cfg_sel` is low.
- R9: With `cfg_sel` low, any mix of two or more of `wr_req`, `rd_req` and `ser_en` does nothing. The offsets and pointers are unchanged and `rb_valid` stays low.
- R10: While `mrst` is high, write, read and serial strobes are ignored. Only the defaults of R1/R2 take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| mrst | input | 1 | Master reset, synchronous, active high |
| cfg_sel | input | 1 | Low: offset access; high: memory access; level at reset picks defaults |
| prog_serial | input | 1 | Loading method sampled at master reset (1 serial, 0 parallel) |
| wr_req | input | 1 | Write strobe, active high |
| rd_req | input | 1 | Read strobe, active high |
| ser_en | input | 1 | Serial shift strobe, active high |
| ser_in | input | 1 | Serial offset bit |
| wdata | input | OFS_W | Parallel offset data |
| empty_ofs | output | OFS_W | Almost-empty threshold offset |
| full_ofs | output | OFS_W | Almost-full threshold offset |
| rb_valid | output | 1 | Readback beat valid, one cycle per read strobe |
| rb_data | output | OFS_W | Readback offset value |
| mem_wr | output | 1 | FIFO array write qualifier |
| mem_rd | output | 1 | FIFO array read qualifier |

## Verification
The bench checks the pointer wrap: a third parallel write or read must fall back on the empty-side register. A design that failed to toggle the pointer, or that toggled it on conflicting strobes, would write to the wrong threshold. The bench also checks the bit order of the serial chain with an asymmetric 32-bit pattern, so that a reversed or off-by-one shift path shows up as swapped or rotated offsets. It also checks mode leakage: parallel writes in serial mode, serial shifts in parallel mode and changes of `prog_serial` outside reset must leave the offsets untouched. Finally, it checks that strobes held during master reset must not disturb the defaults, and that memory qualifiers must never rise while `cfg_sel` is low.

// File: rtl/ofs_loader_pkg.sv
package ofs_loader_pkg;

  localparam logic [31:0] DFLT_LO = 32'h0000_007F;
  localparam logic [31:0] DFLT_HI = 32'h0000_03FF;
  localparam int          NUM_OFS = 2;

  typedef enum logic {
    SIDE_EMPTY = 1'b0,
    SIDE_FULL  = 1'b1
  } ofs_side_e;

  typedef struct packed {
    logic par_wr;
    logic par_rd;
    logic shift;
    logic mem_wr;
    logic mem_rd;
  } access_t;

  function automatic ofs_side_e other_side(input ofs_side_e s);
    return (s == SIDE_EMPTY) ? SIDE_FULL : SIDE_EMPTY;
  endfunction

endpackage

// File: rtl/ofs_access_decode.sv
module ofs_access_decode
  import ofs_loader_pkg::*;
(
  input  logic    mrst,
  input  logic    cfg_sel,
  input  logic    wr_req,
  input  logic    rd_req,
  input  logic    ser_en,
  output access_t acc
);

  logic [1:0] n_strobe;
  logic       cfg_ok;

  always_comb begin
    n_strobe = 2'(wr_req) + 2'(rd_req) + 2'(ser_en);
    cfg_ok   = !mrst && !cfg_sel && (n_strobe == 2'd1);
    acc.par_wr = cfg_ok && wr_req;
    acc.par_rd = cfg_ok && rd_req;
    acc.shift  = cfg_ok && ser_en;
    acc.mem_wr = !mrst && cfg_sel && wr_req;
    acc.mem_rd = !mrst && cfg_sel && rd_req;
  end

endmodule

// File: rtl/ofs_reg_bank.sv
module ofs_reg_bank
  import ofs_loader_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             dflt_hi,
  input  logic             prog_serial,
  input  logic             par_wr,
  input  logic             shift,
  input  logic [OFS_W-1:0] wdata,
  input  logic             ser_in,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs,
  output logic             serial_mode
);

  localparam logic [OFS_W-1:0] LO_VAL = DFLT_LO[OFS_W-1:0];
  localparam logic [OFS_W-1:0] HI_VAL = DFLT_HI[OFS_W-1:0];

  logic [NUM_OFS-1:0][OFS_W-1:0] ofs_q;
  logic [NUM_OFS-1:0]            shift_in;
  logic [OFS_W-1:0]              dflt_val;
  ofs_side_e                     wr_side;
  logic                          do_wr;
  logic                          do_shift;

  assign dflt_val = dflt_hi ? HI_VAL : LO_VAL;
  assign do_wr    = par_wr && !serial_mode;
  assign do_shift = shift && serial_mode;
  // the full side receives the new bit, and its lsb feeds the empty side
  assign shift_in = {ser_in, ofs_q[SIDE_FULL][0]};

  always_ff @(posedge clk) begin
    if (mrst) begin
      serial_mode <= prog_serial;
      wr_side     <= SIDE_EMPTY;
    end else if (do_wr) begin
      wr_side <= other_side(wr_side);
    end
  end

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (mrst) begin
        ofs_q[g] <= dflt_val;
      end else if (do_shift) begin
        ofs_q[g] <= {shift_in[g], ofs_q[g][OFS_W-1:1]};
      end else if (do_wr && (int'(wr_side) == g)) begin
        ofs_q[g] <= wdata;
      end
    end
  end

  assign empty_ofs = ofs_q[SIDE_EMPTY];
  assign full_ofs  = ofs_q[SIDE_FULL];

endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
  import ofs_loader_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             par_rd,
  input  logic [OFS_W-1:0] empty_ofs,
  input  logic [OFS_W-1:0] full_ofs,
  output logic             rb_valid,
  output logic [OFS_W-1:0] rb_data
);

  ofs_side_e rd_side;

  always_ff @(posedge clk) begin
    if (mrst) begin
      rd_side  <= SIDE_EMPTY;
      rb_valid <= 1'b0;
      rb_data  <= '0;
    end else begin
      rb_valid <= par_rd;
      if (par_rd) begin
        rb_data <= (rd_side == SIDE_FULL) ? full_ofs : empty_ofs;
        rd_side <= other_side(rd_side);
      end
    end
  end

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_loader_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             cfg_sel,
  input  logic             prog_serial,
  input  logic             wr_req,
  input  logic             rd_req,
  input  logic             ser_en,
  input  logic             ser_in,
  input  logic [OFS_W-1:0] wdata,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs,
  output logic             rb_valid,
  output logic [OFS_W-1:0] rb_data,
  output logic             mem_wr,
  output logic             mem_rd
);

  access_t acc;
  logic    serial_mode;

  ofs_access_decode u_dec (
    .mrst    (mrst),
    .cfg_sel (cfg_sel),
    .wr_req  (wr_req),
    .rd_req  (rd_req),
    .ser_en  (ser_en),
    .acc     (acc)
  );

  ofs_reg_bank #(.OFS_W(OFS_W)) u_bank (
    .clk         (clk),
    .mrst        (mrst),
    .dflt_hi     (cfg_sel),
    .prog_serial (prog_serial),
    .par_wr      (acc.par_wr),
    .shift       (acc.shift),
    .wdata       (wdata),
    .ser_in      (ser_in),
    .empty_ofs   (empty_ofs),
    .full_ofs    (full_ofs),
    .serial_mode (serial_mode)
  );

  ofs_readback #(.OFS_W(OFS_W)) u_rb (
    .clk       (clk),
    .mrst      (mrst),
    .par_rd    (acc.par_rd),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .rb_valid  (rb_valid),
    .rb_data   (rb_data)
  );

  assign mem_wr = acc.mem_wr;
  assign mem_rd = acc.mem_rd;

endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk #(
  parameter int OFS_W = 16
) (
  input logic             clk,
  input logic             mrst,
  input logic             cfg_sel,
  input logic             wr_req,
  input logic             rd_req,
  input logic             ser_en,
  input logic [OFS_W-1:0] empty_ofs,
  input logic [OFS_W-1:0] full_ofs,
  input logic             rb_valid,
  input logic             mem_wr,
  input logic             mem_rd,
  input logic             serial_mode
);

  localparam logic [OFS_W-1:0] LO = OFS_W'('h7F);
  localparam logic [OFS_W-1:0] HI = OFS_W'('h3FF);

  assert_dflt_lo_R1: assert property (@(posedge clk)
    (mrst && !cfg_sel) |=> (empty_ofs == LO && full_ofs == LO && !rb_valid));

  assert_dflt_hi_R2: assert property (@(posedge clk)
    (mrst && cfg_sel) |=> (empty_ofs == HI && full_ofs == HI));

  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (mrst)
    !mrst |=> $stable(serial_mode));

  assert_par_hold_R4: assert property (@(posedge clk) disable iff (mrst)
    (!serial_mode && !(wr_req && !cfg_sel)) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  assert_ser_hold_R5: assert property (@(posedge clk) disable iff (mrst)
    (serial_mode && !(ser_en && !cfg_sel)) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  assert_rb_beat_R7: assert property (@(posedge clk) disable iff (mrst)
    (!cfg_sel && rd_req && !wr_req && !ser_en) |=> rb_valid);

  assert_no_mem_cfg_R8: assert property (@(posedge clk) disable iff (mrst)
    !cfg_sel |-> (!mem_wr && !mem_rd));

  assert_conflict_nop_R9: assert property (@(posedge clk) disable iff (mrst)
    (!cfg_sel && wr_req && rd_req) |=> (!rb_valid && $stable(empty_ofs) && $stable(full_ofs)));

endmodule

bind ofs_loader ofs_loader_chk #(.OFS_W(OFS_W)) u_chk (
  .clk         (clk),
  .mrst        (mrst),
  .cfg_sel     (cfg_sel),
  .wr_req      (wr_req),
  .rd_req      (rd_req),
  .ser_en      (ser_en),
  .empty_ofs   (empty_ofs),
  .full_ofs    (full_ofs),
  .rb_valid    (rb_valid),
  .mem_wr      (mem_wr),
  .mem_rd      (mem_rd),
  .serial_mode (serial_mode)
);

// File: tb/test_ofs_loader.sv
`timescale 1ns/1ps
module test_ofs_loader;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         mrst, cfg_sel, prog_serial, wr_req, rd_req, ser_en, ser_in;
  logic [W-1:0] wdata;
  logic [W-1:0] empty_ofs, full_ofs, rb_data;
  logic         rb_valid, mem_wr, mem_rd;

  always #2.5 clk = ~clk;

  ofs_loader #(.OFS_W(W)) i_ofs_loader (
    .clk(clk), .mrst(mrst), .cfg_sel(cfg_sel), .prog_serial(prog_serial),
    .wr_req(wr_req), .rd_req(rd_req), .ser_en(ser_en), .ser_in(ser_in),
    .wdata(wdata), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .rb_valid(rb_valid), .rb_data(rb_data), .mem_wr(mem_wr), .mem_rd(mem_rd)
  );

  // behavioural reference state
  logic [W-1:0] m_e, m_f, m_rbd;
  bit           m_rbv, m_ser, m_wp, m_rp;
  int           n_cmp = 0, n_bad = 0, n_cyc = 0;
  string        tag = "R1";

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int nstr;
    logic [2*W-1:0] ch;
    if (mrst) begin
      m_ser = prog_serial;
      m_e = cfg_sel ? W'('h3FF) : W'('h7F);
      m_f = m_e;
      m_wp = 0; m_rp = 0; m_rbv = 0; m_rbd = '0;
    end else begin
      m_rbv = 0;
      nstr = int'(wr_req) + int'(rd_req) + int'(ser_en);
      if (!cfg_sel && nstr == 1) begin
        if (wr_req && !m_ser) begin
          if (m_wp) m_f = wdata; else m_e = wdata;
          m_wp = !m_wp;
        end
        if (rd_req) begin
          m_rbv = 1;
          m_rbd = m_rp ? m_f : m_e;
          m_rp = !m_rp;
        end
        if (ser_en && m_ser) begin
          ch = {m_f, m_e};
          ch = {ser_in, ch[2*W-1:1]};
          m_e = ch[W-1:0];
          m_f = ch[2*W-1:W];
        end
      end
    end
  endtask

  task automatic cyc(input bit r, input bit cs, input bit ps, input bit w, input bit rd,
                     input bit se, input bit si, input logic [W-1:0] d);
    mrst = r; cfg_sel = cs; prog_serial = ps; wr_req = w; rd_req = rd;
    ser_en = se; ser_in = si; wdata = d;
    #1;
    chk("mem_wr", 32'(mem_wr), 32'(!r && cs && w));   // R8
    chk("mem_rd", 32'(mem_rd), 32'(!r && cs && rd));  // R8
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("empty_ofs", 32'(empty_ofs), 32'(m_e));
    chk("full_ofs",  32'(full_ofs),  32'(m_f));
    chk("rb_valid",  32'(rb_valid),  32'(m_rbv));
    chk("rb_data",   32'(rb_data),   32'(m_rbd));
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected below 150000 cycles", n_cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pat;
    pat = 32'hA5C3_1E87;
    // R1 and R10: defaults with cfg_sel low, strobes held in reset ignored
    tag = "R1";
    cyc(1, 0, 0, 0, 0, 0, 0, '0);
    tag = "R10";
    cyc(1, 0, 0, 1, 0, 0, 0, 16'hBEEF);
    cyc(1, 0, 0, 0, 1, 1, 1, 16'h1111);
    chk("R10 empty after reset strobes", 32'(empty_ofs), 32'h7F);
    // R4: parallel writes alternate empty, full, empty
    tag = "R4";
    cyc(0, 0, 0, 1, 0, 0, 0, 16'h1234);
    chk("R4 first write to empty", 32'(empty_ofs), 32'h1234);
    cyc(0, 0, 0, 1, 0, 0, 0, 16'h0ABC);
    chk("R4 second write to full", 32'(full_ofs), 32'h0ABC);
    cyc(0, 0, 0, 1, 0, 0, 0, 16'h5555);
    chk("R4 wrap to empty", 32'(empty_ofs), 32'h5555);
    // R7: readback alternates, one cycle latency
    tag = "R7";
    cyc(0, 0, 0, 0, 1, 0, 0, '0);
    cyc(0, 0, 0, 0, 1, 0, 0, '0);
    cyc(0, 0, 0, 0, 1, 0, 0, '0);
    cyc(0, 0, 0, 0, 0, 0, 0, '0);
    // R5: serial shift ignored in parallel mode
    tag = "R5";
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 1, 1, '0);
    // R9: conflicting strobes do nothing
    tag = "R9";
    cyc(0, 0, 0, 1, 1, 0, 0, 16'hFFFF);
    cyc(0, 0, 0, 1, 0, 1, 1, 16'hFFFF);
    cyc(0, 0, 0, 0, 1, 1, 1, 16'hFFFF);
    cyc(0, 0, 0, 1, 1, 1, 1, 16'hFFFF);
    // R8: memory qualifiers with cfg_sel high, offsets untouched
    tag = "R8";
    cyc(0, 1, 0, 1, 0, 0, 0, 16'h7777);
    cyc(0, 1, 0, 0, 1, 0, 0, '0);
    cyc(0, 1, 0, 1, 1, 1, 1, '0);
    // R3: prog_serial outside reset has no effect
    tag = "R3";
    cyc(0, 0, 1, 1, 0, 0, 0, 16'h2468);
    cyc(0, 0, 1, 0, 0, 1, 1, '0);
    chk("R3 still parallel", 32'(full_ofs), 32'h2468);
    // R2: defaults with cfg_sel high, serial mode
    tag = "R2";
    cyc(1, 1, 1, 0, 0, 0, 0, '0);
    chk("R2 full default", 32'(full_ofs), 32'h3FF);
    // R6: serial bit order
    tag = "R6";
    for (int i = 0; i < 2 * W; i++) cyc(0, 0, 0, 0, 0, 1, pat[i], '0);
    chk("R6 empty after chain", 32'(empty_ofs), 32'h1E87);
    chk("R6 full after chain", 32'(full_ofs), 32'hA5C3);
    // R5: parallel write ignored in serial mode
    tag = "R5";
    cyc(0, 0, 0, 1, 0, 0, 0, 16'h0F0F);
    cyc(0, 0, 0, 1, 0, 0, 0, 16'hF0F0);
    // R7: readback works in serial mode
    tag = "R7";
    cyc(0, 0, 0, 0, 1, 0, 0, '0);
    cyc(0, 0, 0, 0, 1, 0, 0, '0);
    cyc(0, 0, 0, 0, 0, 0, 0, '0);
    // R9: random mixes with occasional reset
    tag = "R9";
    for (int i = 0; i < 600; i++) begin
      cyc(($urandom % 40) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
          $urandom % 2, $urandom % 2, $urandom % 2, W'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule